// File: doc/BRIEF.md
# Multi-Master Two-Wire Bus Master Controller

This block is the bus-master engine for a shared two-wire serial bus (I2C) that other masters may also use. It never drives a line high. It pulls SCL or SDA low by raising the matching output enable, and it lets a line go high by dropping the enable. Both lines come back through two-flop synchronizers. Every level and edge decision uses only the synchronized copies.

A host issues one command at a time, each as a one-cycle pulse on `cmdValid`. The commands are START, WRITE of a byte, READ of a byte with a chosen acknowledge, and STOP. `busy` stays high while a command runs. `done` pulses for one cycle when the command ends. At that point `rdData`, `slaveNack`, `arbLost` and `timeout` hold the result. The SCL half period is set in system clocks through `halfPeriod`. For example, a value of 125 at 100 MHz gives roughly the 400 kbit/s fast-mode rate. The high half is timed from the moment SCL is actually seen high, so a slave or another master that holds SCL low stretches the bit. A stuck-low SCL aborts the command once `stuckLimit` clocks have passed.

The block also watches the bus for START and STOP conditions made by anyone, itself included. It keeps a bus-busy flag from them and refuses to start while another master owns the bus.

Top module: `i2c_bus_master`

## Requirements
- R1: After reset both output enables are 0 (lines released) and busy, done, arbLost, timeout and busBusy are all 0.
- R2: START from an idle bus lowers SDA while SCL is high, then lowers SCL. On done both enables are 1, arbLost is 0 and busBusy is 1.
- R3: WRITE (cmdCode 1) puts cmdData on SDA most significant bit first, one bit per SCL high phase. Outside START and STOP, SDA changes only while SCL is low.
- R4: On the ninth clock of a WRITE the master releases SDA and samples it. slaveNack is 1 when SDA was high and 0 when the slave pulled it low.
- R5: READ (cmdCode 2) releases SDA for eight clocks and returns the sampled byte on rdData, first bit received as bit 7. On the ninth clock it pulls SDA low when cmdNack is 0 and leaves it released when cmdNack is 1.
- R6: STOP (cmdCode 3) lowers SDA while SCL is low, releases SCL, then releases SDA while SCL is high. On done both enables are 0 and busBusy is 0.
- R7: During a WRITE data bit sent as 1, SDA read back low ends the command with arbLost 1 and both enables 0. The block then refuses a new START until the bus sees a STOP.
- R8: The SCL high phase lasts from halfPeriod+1 to halfPeriod+4 clocks from the point the line rises. This holds also after a device has held SCL low for longer than the low phase.
- R9: If SCL stays low for stuckLimit clocks after the master released it, the command ends with timeout 1 and both enables 0.
- R10: A START made on the bus by any device sets busBusy and a STOP clears it. START (cmdCode 0) while busBusy is 1 and the block does not own the bus ends at once with arbLost 1, and neither line is driven.
- R11: busy is 1 from the cycle after a command is accepted until done. done is a single-cycle pulse, seen together with busy 0.
- R12: Between bits the master holds SCL low for halfPeriod clocks (±1) when no device stretches it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfPeriod | input | DIV_W | SCL half period in clocks (at least 2) |
| stuckLimit | input | TMO_W | Clocks SCL may stay low after release before abort |
| cmdValid | input | 1 | One-cycle command request, taken when busy is 0 |
| cmdCode | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmdData | input | 8 | Byte to send for WRITE |
| cmdNack | input | 1 | For READ: 1 leaves SDA released on the ninth clock |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one cycle) |
| rdData | output | 8 | Byte from the last READ |
| slaveNack | output | 1 | Acknowledge bit sampled after the last WRITE |
| arbLost | output | 1 | Last command lost arbitration or was refused |
| timeout | output | 1 | Last command aborted on stuck SCL |
| busBusy | output | 1 | Bus owned between a START and a STOP |

## Verification
Some properties are checked on every cycle. done is a single pulse with busy low. Both enables are released whenever a command ends on lost arbitration or timeout. The synchronized line copies trail the pins by exactly two clocks. A STOP seen on the synchronized lines clears busBusy on the next cycle. Other behaviour only shows through the bench's bus scenarios:
- bit order and the acknowledge handling of both directions;
- that SDA never moves while SCL is high outside START and STOP;
- the measured SCL phase lengths with and without stretching;
- a contending master forcing SDA low;
- a foreign START that makes the block refuse to start;
- a stuck-low SCL that ends in timeout.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture byte to send
    logic sample;     // shift in sampled SDA
    logic ackSample;  // capture slave acknowledge
    logic latchRd;    // publish received byte
  } dpStrobe_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [BYTE_BITS-1:0] cmdData,
  input  dpStrobe_t            stb,
  output logic                 sclSync,
  output logic                 sdaSync,
  output logic                 txBit,
  output logic                 busBusy,
  output logic [BYTE_BITS-1:0] rdData,
  output logic                 slaveNack
);
  logic [BYTE_BITS-1:0] shiftReg;
  logic sclPrev, sdaPrev;
  logic startOnBus, stopOnBus;

  i2cm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sclSync_i (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync));
  i2cm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sdaSync_i (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaSync));

  // bus conditions: SDA edge while SCL stays high
  assign startOnBus = sclSync && sclPrev && sdaPrev && !sdaSync;
  assign stopOnBus  = sclSync && sclPrev && !sdaPrev && sdaSync;
  assign txBit      = shiftReg[BYTE_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      busBusy   <= 1'b0;
      shiftReg  <= '0;
      rdData    <= '0;
      slaveNack <= 1'b0;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
      if (startOnBus)     busBusy <= 1'b1;
      else if (stopOnBus) busBusy <= 1'b0;
      if (stb.load)        shiftReg  <= cmdData;
      else if (stb.sample) shiftReg  <= {shiftReg[BYTE_BITS-2:0], sdaSync};
      if (stb.ackSample)   slaveNack <= sdaSync;
      if (stb.latchRd)     rdData    <= shiftReg;
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic [TMO_W-1:0] stuckLimit,
  input  logic             cmdValid,
  input  logic [1:0]       cmdCode,
  input  logic             cmdNack,
  input  logic             sclSync,
  input  logic             sdaSync,
  input  logic             txBit,
  input  logic             busBusy,
  output dpStrobe_t        stb,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy,
  output logic             done,
  output logic             arbLost,
  output logic             timeout
);
  localparam int BIT_W = $clog2(BYTE_BITS + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_BITS);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SPREP, ST_SRISE, ST_SSETUP, ST_SHOLD,
    ST_BLOW, ST_BRISE, ST_BHIGH, ST_BREL,
    ST_PLOW, ST_PRISE, ST_PSETUP, ST_PFREE
  } state_e;

  state_e           state;
  cmd_e             curCmd;
  logic             nackReq, owner;
  logic [DIV_W-1:0] cnt;
  logic [TMO_W-1:0] tmoCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             tick, isRise, isWrite, arbFail, cmdIsWrite;

  assign cmdIsWrite = (cmd_e'(cmdCode) == CMD_WRITE);
  assign tick    = (cnt >= halfPeriod - DIV_W'(1));
  assign isRise  = (state == ST_SRISE) || (state == ST_BRISE) || (state == ST_PRISE);
  assign isWrite = (curCmd == CMD_WRITE);
  assign arbFail = isWrite && (bitCnt < ACK_SLOT) && txBit && !sdaSync;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb.load      = (state == ST_IDLE) && cmdValid && cmdIsWrite;
    stb.sample    = (state == ST_BHIGH) && (cnt == '0) && (bitCnt < ACK_SLOT);
    stb.ackSample = (state == ST_BHIGH) && (cnt == '0) && (bitCnt == ACK_SLOT) && isWrite;
    stb.latchRd   = (state == ST_BREL) && !isWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curCmd  <= CMD_START;
      nackReq <= 1'b0;
      owner   <= 1'b0;
      cnt     <= '0;
      tmoCnt  <= '0;
      bitCnt  <= '0;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
      done    <= 1'b0;
      arbLost <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + DIV_W'(1);
      if (!isRise)      tmoCnt <= '0;
      else if (!sclSync) tmoCnt <= tmoCnt + TMO_W'(1);

      unique case (state)
        ST_IDLE: if (cmdValid) begin
          curCmd  <= cmd_e'(cmdCode);
          nackReq <= cmdNack;
          cnt     <= '0;
          bitCnt  <= '0;
          arbLost <= 1'b0;
          timeout <= 1'b0;
          unique case (cmd_e'(cmdCode))
            CMD_START: begin
              if (busBusy && !owner) begin
                arbLost <= 1'b1;
                done    <= 1'b1;
              end else begin
                state <= ST_SPREP;
              end
            end
            CMD_WRITE, CMD_READ: state <= ST_BLOW;
            default:             state <= ST_PLOW;
          endcase
        end
        ST_SPREP: begin
          sdaOe <= 1'b0;
          if (tick) begin sclOe <= 1'b0; cnt <= '0; state <= ST_SRISE; end
        end
        ST_SSETUP: if (tick) begin sdaOe <= 1'b1; cnt <= '0; state <= ST_SHOLD; end
        ST_SHOLD: if (tick) begin
          sclOe <= 1'b1; owner <= 1'b1; done <= 1'b1; state <= ST_IDLE;
        end
        ST_BLOW: begin
          sclOe <= 1'b1;
          if (cnt == DIV_W'(1)) begin
            if (bitCnt < ACK_SLOT) sdaOe <= isWrite ? !txBit : 1'b0;
            else                   sdaOe <= isWrite ? 1'b0 : !nackReq;
          end
          if (tick) begin sclOe <= 1'b0; cnt <= '0; state <= ST_BRISE; end
        end
        ST_BHIGH: begin
          if (cnt == '0 && arbFail) begin
            sclOe <= 1'b0; sdaOe <= 1'b0; owner <= 1'b0;
            arbLost <= 1'b1; done <= 1'b1; state <= ST_IDLE;
          end else if (tick || (cnt != '0 && !sclSync)) begin
            // own count ended or another device pulled SCL low early
            sclOe <= 1'b1;
            cnt   <= '0;
            if (bitCnt == ACK_SLOT) state <= ST_BREL;
            else begin bitCnt <= bitCnt + BIT_W'(1); state <= ST_BLOW; end
          end
        end
        ST_BREL: begin sdaOe <= 1'b0; done <= 1'b1; state <= ST_IDLE; end
        ST_PLOW: begin
          sclOe <= 1'b1;
          if (cnt == DIV_W'(1)) sdaOe <= 1'b1;
          if (tick) begin sclOe <= 1'b0; cnt <= '0; state <= ST_PRISE; end
        end
        ST_PSETUP: if (tick) begin sdaOe <= 1'b0; cnt <= '0; state <= ST_PFREE; end
        ST_PFREE: if (tick) begin owner <= 1'b0; done <= 1'b1; state <= ST_IDLE; end
        default: begin // the three rise states: wait for SCL seen high
          if (sclSync) begin
            cnt <= '0;
            if (state == ST_SRISE)      state <= ST_SSETUP;
            else if (state == ST_BRISE) state <= ST_BHIGH;
            else                        state <= ST_PSETUP;
          end else if (tmoCnt >= stuckLimit) begin
            sclOe <= 1'b0; sdaOe <= 1'b0; owner <= 1'b0;
            timeout <= 1'b1; done <= 1'b1; state <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_master.sv
module i2c_bus_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int TMO_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic [TMO_W-1:0] stuckLimit,
  input  logic             cmdValid,
  input  logic [1:0]       cmdCode,
  input  logic [7:0]       cmdData,
  input  logic             cmdNack,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rdData,
  output logic             slaveNack,
  output logic             arbLost,
  output logic             timeout,
  output logic             busBusy
);
  dpStrobe_t stb;
  logic sclSync, sdaSync, txBit;

  i2cm_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmdData(cmdData),
    .stb(stb), .sclSync(sclSync), .sdaSync(sdaSync), .txBit(txBit),
    .busBusy(busBusy), .rdData(rdData), .slaveNack(slaveNack));

  i2cm_ctrl #(.DIV_W(DIV_W), .TMO_W(TMO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .halfPeriod(halfPeriod), .stuckLimit(stuckLimit),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdNack(cmdNack),
    .sclSync(sclSync), .sdaSync(sdaSync), .txBit(txBit), .busBusy(busBusy),
    .stb(stb), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done),
    .arbLost(arbLost), .timeout(timeout));
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sclSync,
  input logic sdaSync,
  input logic sclOe,
  input logic sdaOe,
  input logic busy,
  input logic done,
  input logic arbLost,
  input logic timeout,
  input logic busBusy
);
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN)               upCnt <= '0;
    else if (upCnt != 2'd3)  upCnt <= upCnt + 2'd1;
  end

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r7_arb_release: assert property (@(posedge clk) disable iff (!rstN)
    (done && arbLost) |-> (!sclOe && !sdaOe));
  a_r9_tmo_release: assert property (@(posedge clk) disable iff (!rstN)
    (done && timeout) |-> (!sclOe && !sdaOe));
  a_r8_sync_lag: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (sclSync == $past(sclIn, 2)));
  a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((upCnt == 2'd3) && sclSync && $past(sclSync) && sdaSync && !$past(sdaSync))
      |=> !busBusy);
endmodule

bind i2c_bus_master i2cm_checker chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sclSync(sclSync), .sdaSync(sdaSync),
  .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done), .arbLost(arbLost),
  .timeout(timeout), .busBusy(busBusy));

// File: tb/i2c_bus_master_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_master_tb_top;
  localparam int HALF  = 8;
  localparam int LIMIT = 200;
  localparam int STRETCH = 30;

  logic clk = 0;
  always #2 clk = ~clk;   // 250 MHz

  logic rstN = 0;
  logic cmdValid = 0;
  logic [1:0] cmdCode = 0;
  logic [7:0] cmdData = 0;
  logic cmdNack = 0;
  logic slvSda = 0, slvScl = 0, othSda = 0, othScl = 0;
  logic sclOe, sdaOe, busy, done, slaveNack, arbLost, timeout, busBusy;
  logic [7:0] rdData;
  wire sclLine = !(sclOe || slvScl || othScl);
  wire sdaLine = !(sdaOe || slvSda || othSda);

  i2c_bus_master dut_i (
    .clk(clk), .rstN(rstN), .halfPeriod(12'(HALF)), .stuckLimit(20'(LIMIT)),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdData(cmdData), .cmdNack(cmdNack),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy),
    .done(done), .rdData(rdData), .slaveNack(slaveNack), .arbLost(arbLost),
    .timeout(timeout), .busBusy(busBusy));

  int nChecks = 0, nFails = 0;
  bit allowCond = 1;
  int illegalChg = 0;
  bit sawStart = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // SDA may only move while SCL is low unless a START/STOP is intended (R3)
  always @(posedge sdaLine or negedge sdaLine) begin
    if (sclLine && !allowCond) illegalChg++;
    if (sclLine && !sdaLine) sawStart = 1;
  end

  // SCL phase length measurement at negedge clk (R8, R12)
  bit measEn = 0;
  int runLen = 0, hiMin, hiMax, loMin, loMax;
  logic lastScl = 1;
  always @(negedge clk) begin
    if (sclLine == lastScl) runLen++;
    else begin
      if (measEn && runLen > 0) begin
        if (lastScl) begin
          if (runLen < hiMin) hiMin = runLen;
          if (runLen > hiMax) hiMax = runLen;
        end else begin
          if (runLen < loMin) loMin = runLen;
          if (runLen > loMax) loMax = runLen;
        end
      end
      runLen = 1;
      lastScl = sclLine;
    end
  end

  task automatic measReset();
    hiMin = 9999; hiMax = 0; loMin = 9999; loMax = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] c, input logic [7:0] d, input logic n);
    @(negedge clk);
    cmdCode = c; cmdData = d; cmdNack = n; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic waitDone(input string tag);
    int guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done, {tag, " R11 done seen"}, done, 1);
    chk(!busy, "R11 busy low at done", busy, 0);
    @(negedge clk);
    chk(!done, "R11 done single pulse", done, 0);
  endtask

  task automatic doStart();
    allowCond = 1; sawStart = 0;
    issue(0, 8'h00, 0);
    chk(busy, "R11 busy after accept", busy, 1);
    waitDone("R2");
    allowCond = 0;
    chk(sawStart, "R2 sda fell while scl high", sawStart, 1);
    chk(sclOe && sdaOe && !arbLost, "R2 lines held low", {sclOe, sdaOe, arbLost}, 3'b110);
    chk(busBusy, "R2 busBusy set", busBusy, 1);
  endtask

  task automatic doStop();
    allowCond = 1;
    issue(3, 8'h00, 0);
    waitDone("R6");
    allowCond = 0;
    chk(!sclOe && !sdaOe, "R6 lines released", {sclOe, sdaOe}, 0);
    chk(!busBusy, "R6 busBusy cleared", busBusy, 0);
  endtask

  task automatic doWrite(input logic [7:0] b, input bit slvNack, input int stretchBit);
    logic [7:0] seen = 0;
    issue(1, b, 0);
    for (int i = 0; i < 8; i++) begin
      if (i == stretchBit && i > 0) begin
        @(negedge sclLine); #1 slvScl = 1;
        repeat (STRETCH) @(negedge clk);
        #1 slvScl = 0;
      end
      @(posedge sclLine); #1 seen = {seen[6:0], sdaLine};
    end
    @(negedge sclLine); #1 slvSda = !slvNack;
    @(posedge sclLine); @(negedge sclLine); #1 slvSda = 0;
    waitDone("R3");
    chk(seen == b, "R3 byte on bus msb first", seen, b);
    chk(slaveNack == slvNack, "R4 slave ack status", slaveNack, slvNack);
  endtask

  task automatic doRead(input logic [7:0] b, input bit nack);
    logic ackLvl;
    issue(2, 8'h00, nack);
    slvSda = !b[7];
    for (int i = 7; i >= 0; i--) begin
      @(posedge sclLine); @(negedge sclLine); #1;
      slvSda = (i > 0) ? !b[i-1] : 1'b0;
    end
    @(posedge sclLine); #1 ackLvl = sdaLine;
    @(negedge sclLine);
    waitDone("R5");
    chk(rdData == b, "R5 read data", rdData, b);
    chk(ackLvl == nack, "R5 master ack level", ackLvl, nack);
  endtask

  task automatic foreignStop();
    allowCond = 1;
    othScl = 1; repeat (4) @(negedge clk);
    othSda = 1; repeat (4) @(negedge clk);
    othScl = 0; repeat (6) @(negedge clk);
    othSda = 0; repeat (8) @(negedge clk);
    allowCond = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!sclOe && !sdaOe && !busy && !done && !arbLost && !timeout && !busBusy,
        "R1 reset state", {sclOe, sdaOe, busy, done, arbLost, timeout, busBusy}, 0);

    // directed: address nack, then measured write and stretched write
    doStart();
    doWrite(8'hA4, 1, -1);
    measReset(); measEn = 1;
    doWrite(8'h5B, 0, -1);
    measEn = 0;
    chk(loMin >= HALF - 1 && loMin <= HALF + 1, "R12 low phase length", loMin, HALF);
    chk(hiMin >= HALF + 1 && hiMax <= HALF + 4, "R8 high phase length", hiMax, HALF + 3);
    measReset(); measEn = 1;
    doWrite(8'hC3, 0, 3);
    measEn = 0;
    chk(loMax >= STRETCH, "R8 stretched low extended", loMax, STRETCH);
    chk(hiMin >= HALF + 1 && hiMax <= HALF + 4, "R8 high phase after stretch", hiMin, HALF + 3);
    doRead(8'h96, 0);
    doRead(8'h01, 1);
    doStop();
    chk(illegalChg == 0, "R3 sda stable while scl high", illegalChg, 0);

    // random transactions
    for (int t = 0; t < 6; t++) begin
      logic [6:0] adr = 7'($urandom);
      bit rw = 1'($urandom);
      int n = 1 + int'($urandom % 3);
      doStart();
      doWrite({adr, rw}, 0, -1);
      for (int k = 0; k < n; k++) begin
        if (rw) doRead(8'($urandom), (k == n - 1));
        else    doWrite(8'($urandom), 1'($urandom), -1);
      end
      doStop();
    end
    chk(illegalChg == 0, "R3 random runs sda stable", illegalChg, 0);

    // arbitration loss: another master holds SDA low while a 1 is sent
    doStart();
    allowCond = 1;
    othSda = 1;
    issue(1, 8'hFF, 0);
    waitDone("R7");
    chk(arbLost && !timeout, "R7 arbitration lost flag", arbLost, 1);
    chk(!sclOe && !sdaOe, "R7 lines released", {sclOe, sdaOe}, 0);
    issue(0, 8'h00, 0);
    waitDone("R7");
    chk(arbLost && !sclOe && !sdaOe, "R7 start refused until stop", arbLost, 1);
    repeat (6) @(negedge clk);
    othSda = 0; repeat (8) @(negedge clk);
    chk(!busBusy, "R10 foreign stop clears busy", busBusy, 0);
    allowCond = 0;

    // foreign START makes bus busy, our START refused
    allowCond = 1;
    othSda = 1; repeat (8) @(negedge clk);
    chk(busBusy, "R10 foreign start sets busy", busBusy, 1);
    issue(0, 8'h00, 0);
    waitDone("R10");
    chk(arbLost, "R10 start refused", arbLost, 1);
    chk(!sclOe && !sdaOe, "R10 no line driven", {sclOe, sdaOe}, 0);
    othSda = 0; repeat (8) @(negedge clk);
    chk(!busBusy, "R10 stop clears busy", busBusy, 0);
    allowCond = 0;

    // stuck SCL timeout
    doStart();
    othScl = 1;
    issue(1, 8'hA5, 0);
    waitDone("R9");
    chk(timeout && !arbLost, "R9 timeout flag", timeout, 1);
    chk(!sclOe && !sdaOe, "R9 lines released", {sclOe, sdaOe}, 0);
    allowCond = 1;
    repeat (4) @(negedge clk);
    othScl = 0; repeat (6) @(negedge clk);
    othSda = 1; repeat (6) @(negedge clk);
    othSda = 0; repeat (8) @(negedge clk);
    allowCond = 0;
    foreignStop();
    chk(!busBusy, "R10 bus idle after recovery", busBusy, 0);

    // normal operation resumes
    doStart();
    doWrite(8'h3C, 0, -1);
    doStop();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule